// File: doc/BRIEF.md
# Table-Driven GHASH Chaining Engine

This block keeps the running GHASH value X and folds a stream of 128-bit blocks into it. On each accepted block it forms Y = X xor block and multiplies Y by the hash key H in GF(2^128), consuming one 4-bit digit of Y per clock. Each step looks up one of 16 precomputed 128-bit multiples of H from a key table, shifts the accumulator right by four, and folds the four bits shifted out back in through a fixed 16-entry, 16-bit remainder table. The remainder value lands in the top 16 bits of the accumulator.

The host loads the 16 key multiples through a write port, then streams blocks with a valid strobe. A block is accepted only while the engine is idle. It tags the final block of a message so that the engine pulses done when that block's product is ready. A clear input zeroes X between messages and leaves the key table as it is. Working out the key multiples from H is the host's job.

Top module: `ghash_engine`

## Requirements
- R1: After synchronous reset, hash is all zeros and busy and done are low.
- R2: A cycle with tbl_we high writes tbl_data into key entry tbl_addr. Entry n must hold the product of H and the 4-bit value n: bit 3 of n stands for H itself and bit 0 for H times x^3.
- R3: Bit 127 of a block, and of hash, is the coefficient of x^0 and bit 0 is that of x^127. Multiplying the x^127 term by x wraps around to 0xE1 in bits 127:120.
- R4: When a block is accepted, the new hash value is (X xor blk_data) times H in GF(2^128), using the reduction constant 0xE1.
- R5: An accepted block keeps busy high for exactly 32 cycles. hash takes its new value on the same clock edge where busy falls, and it holds still while busy is high.
- R6: blk_valid and clr are ignored while busy is high. The block in flight produces the same result it would have produced without them.
- R7: done is high for exactly one cycle, on the edge where a block sent with blk_last set finishes. A block without blk_last raises no done.
- R8: clr while idle sets hash to zero on the next edge and keeps the key table. The following block yields blk_data times H.
- R9: If clr and blk_valid are both high while idle, clr wins: X is cleared and the block is not accepted.
- R10: With an all-zero key table, every block gives a zero hash.
- R11: Consecutive blocks chain: each one uses the hash left by the one before it as X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Zero the chaining value when idle |
| tbl_we | input | 1 | Key table write enable |
| tbl_addr | input | 4 | Key table entry index |
| tbl_data | input | 128 | Key table entry value |
| blk_valid | input | 1 | Start request for a data block |
| blk_data | input | 128 | Data block |
| blk_last | input | 1 | Marks the final block of a message |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when a last block finishes |
| hash | output | 128 | Chaining value X |

## Verification
The bench builds the engine with its default widths: 128-bit blocks, 4-bit digits, a 16-entry key table and a 32-step multiply. With these widths a bit-serial reference multiply in the bench checks every result exactly. Three keys bring different paths of the remainder fold into reach. The unit key passes data straight through and exposes any digit or nibble misordering. The key x makes the top-of-field wraparound visible as a single 0xE1 byte. Random keys over a multi-block stream exercise all 16 remainder entries together with chaining.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
    localparam int BLK_W = 128;
    localparam int DIG_W = 4;
    localparam int REM_W = 16;
    localparam int TBL_N = 1 << DIG_W;
    localparam int NDIG  = BLK_W / DIG_W;
    localparam int CNT_W = $clog2(NDIG);
    localparam int TA_W  = $clog2(TBL_N);

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        blk_t             x;
        blk_t             y;
        blk_t             z;
        logic             last;
        logic             done;
    } core_t;

    // Fold value for the digit bits shifted out of the accumulator:
    // each bit contributes the 0xE1 pattern moved to its own weight.
    function automatic logic [REM_W-1:0] rem_val(logic [DIG_W-1:0] r);
        logic [REM_W-1:0] v;
        v = '0;
        for (int b = 0; b < DIG_W; b++) begin
            if (r[b]) v = v ^ (16'hE100 >> (DIG_W - 1 - b));
        end
        return v;
    endfunction
endpackage

// File: rtl/ghash_key_table.sv
module ghash_key_table #(
    parameter int N  = 16,
    parameter int W  = 128,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ghash_rem_lut.sv
module ghash_rem_lut
    import ghash_pkg::*;
#(
    parameter int DW = DIG_W,
    parameter int RW = REM_W,
    localparam int N = 1 << DW
) (
    input  logic [DW-1:0] idx,
    output logic [RW-1:0] val
);
    logic [RW-1:0] lut [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign lut[i] = rem_val(DW'(i));
    end

    assign val = lut[idx];
endmodule

// File: rtl/ghash_digit_step.sv
module ghash_digit_step
    import ghash_pkg::*;
#(
    parameter int W  = BLK_W,
    parameter int DW = DIG_W,
    parameter int RW = REM_W
) (
    input  logic [W-1:0] z_in,
    input  logic [W-1:0] entry,
    input  logic         first,
    output logic [W-1:0] z_out
);
    logic [RW-1:0] fold;
    logic [W-1:0]  shifted;

    ghash_rem_lut #(.DW(DW), .RW(RW)) u_rem (
        .idx (z_in[DW-1:0]),
        .val (fold)
    );

    always_comb begin
        shifted = z_in >> DW;
        if (first) z_out = entry;
        else       z_out = shifted ^ entry ^ {fold, {(W-RW){1'b0}}};
    end
endmodule

// File: rtl/ghash_engine.sv
module ghash_engine
    import ghash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tbl_we,
    input  logic [TA_W-1:0]   tbl_addr,
    input  logic [BLK_W-1:0]  tbl_data,
    input  logic              blk_valid,
    input  logic [BLK_W-1:0]  blk_data,
    input  logic              blk_last,
    output logic              busy,
    output logic              done,
    output logic [BLK_W-1:0]  hash
);
    core_t            core_q, core_d;
    logic [DIG_W-1:0] digit;
    logic [BLK_W-1:0] entry;
    logic [BLK_W-1:0] step_z;

    assign digit = core_q.y[{core_q.cnt, 2'b00} +: DIG_W];

    ghash_key_table #(.N(TBL_N), .W(BLK_W)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (digit),
        .rdata (entry)
    );

    ghash_digit_step #(.W(BLK_W), .DW(DIG_W), .RW(REM_W)) u_step (
        .z_in  (core_q.z),
        .entry (entry),
        .first (core_q.cnt == '0),
        .z_out (step_z)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        case (core_q.st)
            ST_IDLE: begin
                if (clr) begin
                    core_d.x = '0;
                end else if (blk_valid) begin
                    core_d.y    = core_q.x ^ blk_data;
                    core_d.last = blk_last;
                    core_d.cnt  = '0;
                    core_d.st   = ST_RUN;
                end
            end
            default: begin
                core_d.z   = step_z;
                core_d.cnt = core_q.cnt + 1'b1;
                if (core_q.cnt == CNT_W'(NDIG - 1)) begin
                    core_d.x    = step_z;
                    core_d.st   = ST_IDLE;
                    core_d.done = core_q.last;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign busy = (core_q.st == ST_RUN);
    assign done = core_q.done;
    assign hash = core_q.x;
endmodule

// File: rtl/ghash_engine_chk.sv
module ghash_engine_chk
    import ghash_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             blk_valid,
    input logic             busy,
    input logic             done,
    input logic [BLK_W-1:0] hash
);
    logic [7:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (hash == '0 && !busy && !done));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_run == 8'(NDIG));

    a_r5_hash_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(hash));

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_clr_zero: assert property (@(posedge clk) disable iff (rst)
        (!busy && clr) |=> hash == '0);

    a_r9_clr_wins: assert property (@(posedge clk) disable iff (rst)
        (!busy && clr && blk_valid) |=> !busy);

    a_r6_start_idle_only: assert property (@(posedge clk) disable iff (rst)
        (!busy && !clr && blk_valid) |=> busy);
endmodule

bind ghash_engine ghash_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .blk_valid (blk_valid),
    .busy      (busy),
    .done      (done),
    .hash      (hash)
);

// File: tb/ghash_engine_test.sv
module ghash_engine_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         tbl_we = 1'b0;
    logic [3:0]   tbl_addr = '0;
    logic [127:0] tbl_data = '0;
    logic         blk_valid = 1'b0;
    logic [127:0] blk_data = '0;
    logic         blk_last = 1'b0;
    logic         busy, done;
    logic [127:0] hash;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_x;
    logic [127:0] key_h;

    always #5 clk = ~clk;

    ghash_engine uut (
        .clk(clk), .rst(rst), .clr(clr),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .blk_valid(blk_valid), .blk_data(blk_data), .blk_last(blk_last),
        .busy(busy), .done(done), .hash(hash)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mulx(input logic [127:0] v);
        return v[0] ? ((v >> 1) ^ {8'hE1, 120'b0}) : (v >> 1);
    endfunction

    function automatic logic [127:0] gmul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] z = '0;
        logic [127:0] v = b;
        for (int i = 0; i < 128; i++) begin
            if (a[127-i]) z = z ^ v;
            v = mulx(v);
        end
        return z;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic load_key(input logic [127:0] h);
        logic [127:0] t8, t4, t2, t1, e;
        t8 = h; t4 = mulx(t8); t2 = mulx(t4); t1 = mulx(t2);
        key_h = h;
        for (int i = 0; i < 16; i++) begin
            e = (i[3] ? t8 : '0) ^ (i[2] ? t4 : '0) ^ (i[1] ? t2 : '0) ^ (i[0] ? t1 : '0);
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 4'(i); tbl_data = e;
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_x = '0;
    endtask

    // Sends one block; optionally injects start and clear requests mid-run.
    task automatic run_block(input logic [127:0] d, input bit last, input bit inject,
                             output int cycles, output bit done_end, output bit done_after);
        @(negedge clk);
        blk_valid = 1'b1; blk_data = d; blk_last = last;
        @(negedge clk);
        blk_valid = 1'b0; blk_last = 1'b0;
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            if (inject && cycles >= 5 && cycles <= 7) begin
                blk_valid = 1'b1; clr = 1'b1; blk_data = ~d;
            end else begin
                blk_valid = 1'b0; clr = 1'b0;
            end
            @(negedge clk);
        end
        blk_valid = 1'b0; clr = 1'b0;
        done_end = done;
        exp_x = gmul(exp_x ^ d, key_h);
        @(negedge clk);
        done_after = done;
    endtask

    task automatic t_reset();
        chk(hash == '0, "R1 hash", hash, '0);
        chk(!busy, "R1 busy", 128'(busy), '0);
        chk(!done, "R1 done", 128'(done), '0);
    endtask

    task automatic t_identity();
        int c; bit de, da;
        logic [127:0] d;
        load_key({1'b1, 127'b0});
        do_clr();
        d = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        run_block(d, 1'b1, 1'b0, c, de, da);
        chk(hash == d, "R4 R2 unit key", hash, d);
        chk(c == 32, "R5 busy cycles", 128'(c), 128'd32);
        chk(de, "R7 done on last", 128'(de), 128'd1);
        chk(!da, "R7 done one cycle", 128'(da), '0);
    endtask

    task automatic t_bitorder();
        int c; bit de, da;
        load_key({2'b01, 126'b0});
        do_clr();
        run_block({1'b1, 127'b0}, 1'b0, 1'b0, c, de, da);
        chk(hash == {2'b01, 126'b0}, "R3 x0 times x", hash, {2'b01, 126'b0});
        chk(!de, "R7 no done without last", 128'(de), '0);
        do_clr();
        run_block(128'd1, 1'b0, 1'b0, c, de, da);
        chk(hash == {8'hE1, 120'b0}, "R3 wraparound", hash, {8'hE1, 120'b0});
    endtask

    task automatic t_zero_key();
        int c; bit de, da;
        load_key('0);
        run_block(rnd128(), 1'b1, 1'b0, c, de, da);
        chk(hash == '0, "R10 zero key", hash, '0);
    endtask

    task automatic t_stream();
        int c; bit de, da;
        load_key(rnd128());
        do_clr();
        for (int b = 0; b < 6; b++) begin
            run_block(rnd128(), b == 5, 1'b0, c, de, da);
            chk(hash == exp_x, "R11 R4 R2 chained block", hash, exp_x);
            chk(de == (b == 5), "R7 done flag", 128'(de), 128'(b == 5));
        end
    endtask

    task automatic t_busy_ignore();
        int c; bit de, da;
        run_block(rnd128(), 1'b1, 1'b1, c, de, da);
        chk(hash == exp_x, "R6 requests while busy", hash, exp_x);
        chk(c == 32, "R6 busy cycles", 128'(c), 128'd32);
        @(negedge clk);
        chk(!busy, "R6 no extra block", 128'(busy), '0);
    endtask

    task automatic t_clear();
        int c; bit de, da;
        logic [127:0] d;
        chk(hash != '0, "R8 precondition", hash, exp_x);
        do_clr();
        chk(hash == '0, "R8 clear", hash, '0);
        d = rnd128();
        run_block(d, 1'b0, 1'b0, c, de, da);
        chk(hash == gmul(d, key_h), "R8 key kept", hash, gmul(d, key_h));
        @(negedge clk);
        clr = 1'b1; blk_valid = 1'b1; blk_data = rnd128();
        @(negedge clk);
        clr = 1'b0; blk_valid = 1'b0;
        exp_x = '0;
        chk(!busy, "R9 clear wins busy", 128'(busy), '0);
        chk(hash == '0, "R9 clear wins hash", hash, '0);
    endtask

    initial begin
        exp_x = '0;
        key_h = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_identity();
        t_bitorder();
        t_zero_key();
        t_stream();
        t_busy_ignore();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule